// File: doc/BRIEF.md
# Four-Level Address Translation Walker

The walker turns a 64-bit virtual address into a 40-bit physical address. It reads four levels of translation tables held in memory. A request carries the virtual address and three access flags: write, user-mode and instruction fetch. The walker first confirms that the address is canonical. It then reads one 8-byte entry per level through a request/response memory port. The levels are taken top map first, then directory-pointer, directory and page table. Each entry supplies the base of the next table, and the last entry supplies the frame base. The frame base is joined with the 12-bit page offset to form the result.

Every entry is checked for presence and for the rights the request needs. The walk stops on the first entry that fails, and the walker reports a cause code and the level of that entry. Only one walk is in flight at a time. A new request is taken only once the previous walk has ended with a one-cycle done or fault pulse.

Top module: `ptw_walker`

## Requirements
- R1: The table index for level L (L=0 top map, 1 directory-pointer, 2 directory, 3 page table) is virtual-address bits [47-9L : 39-9L]. The entry read for level L is at table base + index*8. The levels are read strictly in the order 0, 1, 2, 3, with exactly one read per level.
- R2: The level-0 table base is `root_base` bits 39:12 with the low 12 bits forced to zero. The base for each later level is bits 39:12 of the entry read at the level before it.
- R3: A request whose bits 63:48 are not all equal to bit 47 issues no memory read. It gives `fault` one cycle after acceptance, with cause 0 and level 0.
- R4: An entry with bit 0 (present) clear ends the walk with cause 1 at that entry's level, and no further reads are issued.
- R5: A write request whose entry has bit 1 (writable) clear at any level faults with cause 2 at the first such level.
- R6: A user request whose entry has bit 2 (user) clear at any level faults with cause 3 at the first such level.
- R7: A fetch request whose entry has bit 63 set faults with cause 4, but only while `nx_enable` is 1. While `nx_enable` is 0, bit 63 has no effect.
- R8: A walk with no fault pulses `done` one cycle after the page-table response. `paddr` is then {page-table entry bits 39:12, vaddr bits 11:0}. Entry bits 62:40 and 11:3 never change any address.
- R9: `req_ready` is high only while no walk is in flight and no done or fault pulse is showing. Requests offered while busy are ignored. `done` and `fault` never pulse together. A memory read held without `mem_req_ready` keeps its address stable.
- R10: When one entry fails several checks, the cause reported is the first failing one in this order: not-present, then write, then user, then execute-disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nx_enable | input | 1 | Makes entry bit 63 block fetches; sampled when a request is accepted |
| root_base | input | 40 | Top-level table base; bits 11:0 are ignored |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 64 | Virtual address to translate |
| req_write | input | 1 | Request needs write permission |
| req_user | input | 1 | Request is made from user mode |
| req_fetch | input | 1 | Request is an instruction fetch |
| mem_req_valid | output | 1 | Entry read requested |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 40 | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry value |
| done | output | 1 | One-cycle pulse: translation succeeded |
| fault | output | 1 | One-cycle pulse: translation failed |
| fault_cause | output | 3 | 0 non-canonical, 1 not-present, 2 write, 3 user, 4 execute-disable |
| fault_level | output | 2 | Level (0..3) of the entry that failed |
| paddr | output | 40 | Physical address, valid with `done` |

## Verification
The bench builds the walker with its default parameters: a 64-bit virtual address, a 40-bit physical address and four 9-bit levels. With these values both canonical halves of the address space are reachable, and so are faults at every one of the four levels. The tables in memory carry junk in the ignored entry bits. They also combine several failing rights in one entry, which exposes the address-field slicing and the order in which causes are ranked. The memory side varies its ready and response latency per read, so address holding and the one-walk-at-a-time rule are exercised against stalls.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;
  localparam int ENT_P  = 0;
  localparam int ENT_W  = 1;
  localparam int ENT_U  = 2;
  localparam int ENT_XD = 63;

  typedef enum logic [2:0] {
    FC_NONCANON = 3'd0,
    FC_ABSENT   = 3'd1,
    FC_WRPROT   = 3'd2,
    FC_USRPROT  = 3'd3,
    FC_XPROT    = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } walk_st_e;
endpackage

// File: rtl/ptw_canon_chk.sv
`timescale 1ns/1ps
module ptw_canon_chk #(
  parameter int VA_W   = 64,
  parameter int IMPL_W = 48
) (
  input  logic [VA_W-1:0] vaddr,
  output logic            canonical
);
  localparam int EXT_W = VA_W - IMPL_W + 1;

  logic [EXT_W-1:0] ext;
  logic [IMPL_W-2:0] unused_low;

  assign ext        = vaddr[VA_W-1:IMPL_W-1];
  assign unused_low = vaddr[IMPL_W-2:0];
  assign canonical  = (&ext) | ~(|ext);
endmodule

// File: rtl/ptw_index_sel.sv
`timescale 1ns/1ps
module ptw_index_sel #(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  localparam int FLD_W = LEVELS * IDX_W,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [FLD_W-1:0] va_fields,
  input  logic [LVL_W-1:0] level,
  output logic [IDX_W-1:0] index
);
  logic [IDX_W-1:0] per_level [LEVELS];

  genvar g;
  generate
    for (g = 0; g < LEVELS; g++) begin : g_field
      assign per_level[g] = va_fields[IDX_W*(LEVELS-1-g) +: IDX_W];
    end
  endgenerate

  assign index = per_level[level];
endmodule

// File: rtl/ptw_entry_check.sv
`timescale 1ns/1ps
module ptw_entry_check
  import ptw_pkg::*;
#(
  parameter int PA_W  = 40,
  parameter int OFF_W = 12,
  localparam int PFN_W = PA_W - OFF_W
) (
  input  logic [63:0]      entry,
  input  logic             want_wr,
  input  logic             want_usr,
  input  logic             want_fetch,
  input  logic             nx_on,
  output logic             ok,
  output fault_e           cause,
  output logic [PFN_W-1:0] next_base
);
  logic unused_entry;
  assign unused_entry = ^{entry[ENT_XD-1:PA_W], entry[OFF_W-1:ENT_U+1]};

  assign next_base = entry[PA_W-1:OFF_W];

  always_comb begin
    ok    = 1'b1;
    cause = FC_ABSENT;
    if (!entry[ENT_P]) begin
      ok    = 1'b0;
      cause = FC_ABSENT;
    end else if (want_wr && !entry[ENT_W]) begin
      ok    = 1'b0;
      cause = FC_WRPROT;
    end else if (want_usr && !entry[ENT_U]) begin
      ok    = 1'b0;
      cause = FC_USRPROT;
    end else if (want_fetch && nx_on && entry[ENT_XD]) begin
      ok    = 1'b0;
      cause = FC_XPROT;
    end
  end
endmodule

// File: rtl/ptw_walker.sv
`timescale 1ns/1ps
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_W        = 64,
  parameter int PA_W        = 40,
  parameter int LEVELS      = 4,
  parameter int IDX_W       = 9,
  parameter int OFF_W       = 12,
  parameter int ENTRY_BYTES = 8,
  localparam int IMPL_W = OFF_W + LEVELS * IDX_W,
  localparam int PFN_W  = PA_W - OFF_W,
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int ENT_SH = $clog2(ENTRY_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nx_enable,
  input  logic [PA_W-1:0]  root_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic             req_user,
  input  logic             req_fetch,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [63:0]      mem_rsp_data,
  output logic             done,
  output logic             fault,
  output logic [2:0]       fault_cause,
  output logic [LVL_W-1:0] fault_level,
  output logic [PA_W-1:0]  paddr
);
  walk_st_e          state;
  logic [LVL_W-1:0]  lvl_q;
  logic [PFN_W-1:0]  base_q;
  logic [IMPL_W-1:0] va_q;
  logic              wr_q, usr_q, fx_q, nx_q;
  fault_e            cause_q;

  logic              in_canon;
  logic [IDX_W-1:0]  idx;
  logic              ent_ok;
  fault_e            ent_cause;
  logic [PFN_W-1:0]  ent_base;
  logic [OFF_W-1:0]  unused_root;

  assign unused_root = root_base[OFF_W-1:0];

  ptw_canon_chk #(.VA_W(VA_W), .IMPL_W(IMPL_W)) u_canon (
    .vaddr     (req_vaddr),
    .canonical (in_canon)
  );

  ptw_index_sel #(.LEVELS(LEVELS), .IDX_W(IDX_W)) u_idx (
    .va_fields (va_q[IMPL_W-1:OFF_W]),
    .level     (lvl_q),
    .index     (idx)
  );

  ptw_entry_check #(.PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
    .entry      (mem_rsp_data),
    .want_wr    (wr_q),
    .want_usr   (usr_q),
    .want_fetch (fx_q),
    .nx_on      (nx_q),
    .ok         (ent_ok),
    .cause      (ent_cause),
    .next_base  (ent_base)
  );

  assign req_ready     = (state == ST_IDLE) && !done && !fault;
  assign mem_req_valid = (state == ST_ISSUE);
  assign mem_req_addr  = {base_q, {OFF_W{1'b0}}} + PA_W'({idx, {ENT_SH{1'b0}}});
  assign fault_cause   = cause_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      lvl_q       <= '0;
      base_q      <= '0;
      va_q        <= '0;
      wr_q        <= 1'b0;
      usr_q       <= 1'b0;
      fx_q        <= 1'b0;
      nx_q        <= 1'b0;
      cause_q     <= FC_NONCANON;
      fault_level <= '0;
      paddr       <= '0;
      done        <= 1'b0;
      fault       <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            va_q  <= req_vaddr[IMPL_W-1:0];
            wr_q  <= req_write;
            usr_q <= req_user;
            fx_q  <= req_fetch;
            nx_q  <= nx_enable;
            lvl_q <= '0;
            if (!in_canon) begin
              fault       <= 1'b1;
              cause_q     <= FC_NONCANON;
              fault_level <= '0;
            end else begin
              base_q <= root_base[PA_W-1:OFF_W];
              state  <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (mem_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (!ent_ok) begin
              fault       <= 1'b1;
              cause_q     <= ent_cause;
              fault_level <= lvl_q;
              state       <= ST_IDLE;
            end else if (lvl_q == LVL_W'(LEVELS - 1)) begin
              done  <= 1'b1;
              paddr <= {ent_base, va_q[OFF_W-1:0]};
              state <= ST_IDLE;
            end else begin
              base_q <= ent_base;
              lvl_q  <= lvl_q + 1'b1;
              state  <= ST_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_READ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R9
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    !(done && fault)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req_valid); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[ENT_SH-1:0] == '0)); // R1
  AST_NONCANON_FAST: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready &&
     !((&req_vaddr[VA_W-1:IMPL_W-1]) || !(|req_vaddr[VA_W-1:IMPL_W-1])))
    |=> (fault && fault_cause == 3'd0 && fault_level == '0 && !mem_req_valid)); // R3
  AST_ABSENT_STOPS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && mem_rsp_valid && !mem_rsp_data[ENT_P])
    |=> (fault && fault_cause == 3'd1 && !mem_req_valid)); // R4
endmodule

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;
  localparam logic [39:0] ROOT   = 40'h00_0010_0ABC;
  localparam logic [39:0] PFMASK = 40'hFF_FFFF_F000;
  localparam logic [63:0] JUNK   = 64'h000F_FF00_0000_0020;
  localparam logic [63:0] FP = 64'h1, FW = 64'h2, FU = 64'h4;
  localparam logic [63:0] FX = 64'h8000_0000_0000_0000;
  localparam logic [63:0] FULL = FP | FW | FU;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, nx_enable, req_valid, req_ready, req_write, req_user, req_fetch;
  logic [39:0] root_base, mem_req_addr, paddr;
  logic [63:0] req_vaddr, mem_rsp_data;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid, done, fault;
  logic [2:0]  fault_cause;
  logic [1:0]  fault_level;

  ptw_walker u_dut (
    .clk(clk), .rst(rst), .nx_enable(nx_enable), .root_base(root_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user), .req_fetch(req_fetch),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault),
    .fault_cause(fault_cause), .fault_level(fault_level), .paddr(paddr)
  );

  int checks = 0, errors = 0, cycles = 0;
  logic [63:0] mem [logic [39:0]];
  logic [39:0] next_tbl = 40'h00_0020_0000;
  logic [39:0] exp_q [$];
  logic        e_fault;
  int          e_cause, e_level;
  logic [39:0] e_pa;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [63:0] rd(input logic [39:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // Lay down one path of tables for va; flags per level, final frame base.
  task automatic build(input logic [63:0] va, input logic [63:0] f0, input logic [63:0] f1,
                       input logic [63:0] f2, input logic [63:0] f3, input logic [39:0] frame);
    logic [63:0] fl [4];
    logic [39:0] base, nb, a;
    fl[0] = f0; fl[1] = f1; fl[2] = f2; fl[3] = f3;
    base = ROOT & PFMASK;
    for (int l = 0; l < 4; l++) begin
      a = base + 40'((va >> (39 - 9 * l)) & 64'h1FF) * 40'd8;
      if (l < 3) begin
        nb = next_tbl;
        next_tbl = next_tbl + 40'h1000;
      end else nb = frame & PFMASK;
      mem[a] = {24'h0, nb} | fl[l] | JUNK;
      base = nb;
    end
  endtask

  task automatic ref_walk(input logic [63:0] va, input bit w, input bit u, input bit f, input bit nx);
    logic [39:0] base, a;
    logic [63:0] e;
    exp_q.delete();
    e_fault = 1'b0; e_cause = 0; e_level = 0; e_pa = '0;
    if (va[63:48] != {16{va[47]}}) begin
      e_fault = 1'b1;
      return;
    end
    base = ROOT & PFMASK;
    for (int l = 0; l < 4; l++) begin
      a = base + 40'((va >> (39 - 9 * l)) & 64'h1FF) * 40'd8;
      exp_q.push_back(a);
      e = rd(a);
      e_level = l;
      if (!e[0])                 begin e_fault = 1'b1; e_cause = 1; return; end
      if (w && !e[1])            begin e_fault = 1'b1; e_cause = 2; return; end
      if (u && !e[2])            begin e_fault = 1'b1; e_cause = 3; return; end
      if (f && nx && e[63])      begin e_fault = 1'b1; e_cause = 4; return; end
      base = e[39:0] & PFMASK;
    end
    e_pa = base | {28'h0, va[11:0]};
  endtask

  task automatic run_walk(input logic [63:0] va, input bit w, input bit u, input bit f,
                          input bit nx, input bit poke, input int seed, input string req);
    int rsp_cnt = 0;
    int n = 0;
    logic [39:0] pend = '0;
    bit fin = 0;
    ref_walk(va, w, u, f, nx);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = w; req_user = u;
    req_fetch = f; nx_enable = nx;
    while (!fin) begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        if (poke) begin
          req_vaddr = 64'h0000_0012_3456_7000; req_write = 1'b0; req_user = 1'b0; nx_enable = 1'b0;
        end else req_valid = 1'b0;
      end
      mem_rsp_valid = 1'b0;
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd(pend);
        end
      end
      if (done || fault) begin
        req_valid = 1'b0;
        chk(fault == e_fault, req, "fault vs done", {63'h0, fault}, {63'h0, e_fault});
        if (e_fault) begin
          chk(fault_cause == 3'(e_cause), req, "fault cause", 64'(fault_cause), 64'(e_cause));
          chk(fault_level == 2'(e_level), req, "fault level", 64'(fault_level), 64'(e_level));
        end else begin
          chk(paddr == e_pa, req, "physical address (R8)", 64'(paddr), 64'(e_pa));
        end
        chk(exp_q.size() == 0, "R1", "reads left unissued", 64'(exp_q.size()), 64'h0);
        chk(!req_ready, "R9", "ready during result pulse", {63'h0, req_ready}, 64'h0);
        fin = 1;
      end else begin
        mem_req_ready = ((n + seed) % 3) != 2;
        if (mem_req_valid && mem_req_ready) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R3 R4", "unexpected table read", 64'(mem_req_addr), 64'h0);
          end else begin
            logic [39:0] ea;
            ea = exp_q.pop_front();
            chk(mem_req_addr == ea, "R1 R2", "entry address", 64'(mem_req_addr), 64'(ea));
          end
          pend    = mem_req_addr;
          rsp_cnt = 1 + ((n + seed) % 3);
        end
      end
      if (n > 300) begin
        chk(1'b0, req, "walk timeout", 64'(n), 64'd300);
        fin = 1;
      end
    end
    mem_req_ready = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);
    chk(req_ready, "R9", "ready after result", {63'h0, req_ready}, 64'h1);
  endtask

  function automatic logic [63:0] mkva(input logic s, input int i0, input int i1,
                                       input int i2, input int i3, input int off);
    return {{16{s}}, 9'(i0), 9'(i1), 9'(i2), 9'(i3), 12'(off)};
  endfunction

  initial begin
    logic [63:0] va;
    rst = 1'b1; nx_enable = 1'b0; root_base = ROOT; req_valid = 1'b0; req_vaddr = '0;
    req_write = 1'b0; req_user = 1'b0; req_fetch = 1'b0; mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !done && !fault && !mem_req_valid, "R9", "reset state",
        {60'h0, req_ready, done, fault, mem_req_valid}, 64'h8);

    // R8 R1 R2: plain lower-half read
    va = mkva(1'b0, 1, 2, 3, 4, 'h5A5);
    build(va, FULL, FULL, FULL, FULL, 40'h12_3456_7000);
    run_walk(va, 0, 0, 0, 0, 0, 0, "R8");
    // R8: upper half, write + user, all levels allow
    va = mkva(1'b1, 300, 7, 8, 9, 'hFFF);
    build(va, FULL, FULL, FULL, FULL, 40'hAB_CDEF_1000);
    run_walk(va, 1, 1, 0, 0, 0, 1, "R8");
    // R3: non-canonical, both flavours
    run_walk(64'h0001_0000_0000_1000, 0, 0, 0, 0, 0, 2, "R3");
    run_walk(mkva(1'b1, 5, 0, 0, 0, 0) & 64'hFFFF_7FFF_FFFF_FFFF, 0, 0, 0, 0, 0, 0, "R3");
    // R4: missing directory entry, and missing top entry
    va = mkva(1'b0, 10, 1, 1, 1, 0);
    build(va, FULL, FULL, 64'h0, FULL, 40'h00_0777_0000);
    run_walk(va, 0, 0, 0, 0, 0, 1, "R4");
    run_walk(mkva(1'b0, 200, 0, 0, 0, 0), 0, 0, 0, 0, 0, 2, "R4");
    // R5: directory-pointer read-only
    va = mkva(1'b0, 11, 2, 2, 2, 'h010);
    build(va, FULL, FP | FU, FULL, FULL, 40'h00_0888_0000);
    run_walk(va, 1, 0, 0, 0, 0, 0, "R5");
    run_walk(va, 0, 0, 0, 0, 0, 2, "R5");
    // R6: page-table entry supervisor-only
    va = mkva(1'b0, 12, 3, 3, 3, 'h020);
    build(va, FULL, FULL, FULL, FP | FW, 40'h00_0999_0000);
    run_walk(va, 0, 1, 0, 0, 0, 1, "R6");
    run_walk(va, 1, 0, 0, 0, 0, 0, "R6");
    // R7: execute-disable at top level, gated by nx_enable
    va = mkva(1'b0, 13, 4, 4, 4, 'h030);
    build(va, FULL | FX, FULL, FULL, FULL, 40'h00_0AAA_0000);
    run_walk(va, 0, 0, 1, 0, 0, 2, "R7");
    run_walk(va, 0, 0, 1, 1, 0, 0, "R7");
    run_walk(va, 0, 1, 0, 1, 0, 1, "R7");
    // R10: several failures in one entry
    va = mkva(1'b0, 14, 5, 5, 5, 'h040);
    build(va, FULL, FULL, FP | FX, FULL, 40'h00_0BBB_0000);
    run_walk(va, 1, 1, 1, 1, 0, 0, "R10");
    run_walk(va, 0, 1, 1, 1, 0, 1, "R10");
    run_walk(va, 0, 0, 1, 1, 0, 2, "R10");
    va = mkva(1'b0, 15, 6, 6, 6, 'h050);
    build(va, FULL, FW | FU | FX, FULL, FULL, 40'h00_0CCC_0000);
    run_walk(va, 1, 1, 1, 1, 0, 0, "R10");
    // R9: request held high with other contents while busy is ignored
    run_walk(mkva(1'b0, 1, 2, 3, 4, 'h5A5), 0, 0, 0, 0, 1, 1, "R9");
    run_walk(mkva(1'b1, 300, 7, 8, 9, 'h123), 1, 1, 0, 0, 1, 2, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule